// File: doc/BRIEF.md
# Display Auxiliary Channel Register File

This block is the software-facing register file of a display auxiliary channel. Software loads an outgoing message of up to twenty bytes into five 32-bit data words. It then writes the control word with the busy bit set to launch a transfer. A link-side engine raises a request, reads the message one byte at a time, writes back any reply bytes and pulses an acknowledge along with its completion status.

After that the control word reports the outcome. It shows a done flag, a timeout flag and a receive-error flag, all sticky. It also shows the count of bytes that came back. An interrupt line follows the done flag when interrupts are enabled. The control word also holds the timing settings the link engine consumes: the bit-clock divider, the extra precharge length and the timeout limit code. They are driven out as configuration outputs.

Top module: `aux_regs`

## Requirements
- R1: After reset the control word reads busy, done, timeout, receive-error and interrupt-enable as 0, size 0, timeout code 0, precharge 3 and divider round(CLK_KHZ/2000), which is 50 at the default 100000 kHz. The data words read 0 and irq is low.
- R2: Message byte k is taken from data word k/4, byte lane k%4, with lane 0 in bits 31:24 and lane 3 in bits 7:0. Data word n is register address n+1 and the control word is address 0.
- R3: A control write with bit 31 set while idle starts a transfer. Busy (bit 31) and linkReq go high on the next cycle, and linkTxLen equals the size field (bits 24:20) that was written. Busy stays high until linkAck arrives.
- R4: The cycle after linkAck while busy, busy reads 0 and done (bit 30) reads 1. Timeout (bit 28) is set if linkTimeout was high. Without a timeout, the size field takes linkRxLen. An acknowledge while idle has no effect.
- R5: Receive-error (bit 25) is set on completion when linkRxErr is high, or when there is no timeout and linkRxLen is 0 or greater than 20.
- R6: Done, timeout and receive-error stay set until a control write carries a 1 in that bit position. A 0 in that position leaves the flag unchanged.
- R7: While busy, writes to the control word and to the data words are ignored. This includes a second start, so the size field, the fields driven out and the data words keep their values.
- R8: While busy, linkRxWe writes linkRxByte into message byte linkRxIdx, using the lane order of R2. While idle, it is ignored.
- R9: irq is high exactly while done is 1 and interrupt-enable (bit 29) is 1.
- R10: An idle control write loads the divider (bits 10:0), the precharge count in 2 us units (bits 19:16) and the timeout code (bits 27:26; 0=400 us, 1=600 us, 2=800 us, 3=1600 us). These values appear on cfgClkDiv, cfgPrecharge and cfgTimeoutSel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address: 0 control, 1..5 data |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data at regAddr |
| linkReq | output | 1 | Transfer in flight |
| linkTxLen | output | 5 | Byte count to send |
| linkTxIdx | input | 5 | Message byte index read by the link |
| linkTxByte | output | 8 | Message byte at linkTxIdx |
| linkRxWe | input | 1 | Reply byte write strobe |
| linkRxIdx | input | 5 | Reply byte index |
| linkRxByte | input | 8 | Reply byte value |
| linkAck | input | 1 | Transfer complete pulse |
| linkTimeout | input | 1 | Completion ended by timeout |
| linkRxErr | input | 1 | Completion saw a receive error |
| linkRxLen | input | 5 | Reply byte count |
| cfgClkDiv | output | 11 | Bit-clock divider setting |
| cfgPrecharge | output | 4 | Extra precharge, 2 us units |
| cfgTimeoutSel | output | 2 | Timeout limit code |
| irq | output | 1 | Completion interrupt |

## Verification
The situation hardest to reach from the ports is a register write that lands in the middle of a transfer, after busy has risen and before the acknowledge. The bench stalls its link model at that point on every transaction. It then issues a second start with a different size and overwrites a data word. After that it checks the size field, linkTxLen and the data word before releasing the acknowledge. Random reply lengths include 0 and values above 20, and these mix with random timeout and error completions so that every combination of flags is produced.

// File: rtl/aux_regs_pkg.sv
package aux_regs_pkg;
  localparam int WORDS    = 5;
  localparam int BYTES    = WORDS * 4;
  localparam int LEN_W    = $clog2(BYTES + 1);
  localparam int ADDR_W   = $clog2(WORDS + 1);
  localparam int DIV_W    = 11;
  localparam int PRE_W    = 4;
  localparam int TSEL_W   = 2;

  localparam int BIT_BUSY  = 31;
  localparam int BIT_DONE  = 30;
  localparam int BIT_IEN   = 29;
  localparam int BIT_TOUT  = 28;
  localparam int TSEL_LO   = 26;
  localparam int BIT_RXERR = 25;
  localparam int LEN_LO    = 20;
  localparam int PRE_LO    = 16;
  localparam int PRE_RESET = 3;

  typedef struct packed {
    logic              swWe;
    logic [ADDR_W-1:0] swWord;
    logic              rxWe;
  } dpStrobe_t;
endpackage

// File: rtl/aux_regs_ctrl.sv
module aux_regs_ctrl
  import aux_regs_pkg::*;
#(
  parameter int CLK_KHZ = 100000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  input  logic              linkAck,
  input  logic              linkTimeout,
  input  logic              linkRxErr,
  input  logic [LEN_W-1:0]  linkRxLen,
  input  logic              linkRxWe,
  input  logic [LEN_W-1:0]  linkRxIdx,
  output dpStrobe_t         strb,
  output logic              busy,
  output logic [31:0]       ctrlWord,
  output logic [DIV_W-1:0]  clkDiv,
  output logic [PRE_W-1:0]  precharge,
  output logic [TSEL_W-1:0] timeoutSel,
  output logic              irq
);
  localparam logic [DIV_W-1:0] DIV_RESET = DIV_W'((CLK_KHZ + 1000) / 2000);

  logic             done, irqEn, toErr, rxErr;
  logic [LEN_W-1:0] msgSize;
  logic             ctrlWr, badLen;

  assign ctrlWr = regWe && (regAddr == '0) && !busy;
  assign badLen = (linkRxLen == '0) || (linkRxLen > LEN_W'(BYTES));

  always_comb begin
    strb.swWe   = regWe && !busy && (regAddr != '0) && (regAddr <= ADDR_W'(WORDS));
    strb.swWord = regAddr - ADDR_W'(1);
    strb.rxWe   = linkRxWe && busy && (linkRxIdx < LEN_W'(BYTES));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      irqEn      <= 1'b0;
      toErr      <= 1'b0;
      rxErr      <= 1'b0;
      msgSize    <= '0;
      timeoutSel <= '0;
      precharge  <= PRE_W'(PRE_RESET);
      clkDiv     <= DIV_RESET;
    end else if (ctrlWr) begin
      busy       <= regWdata[BIT_BUSY];
      irqEn      <= regWdata[BIT_IEN];
      timeoutSel <= regWdata[TSEL_LO +: TSEL_W];
      msgSize    <= regWdata[LEN_LO +: LEN_W];
      precharge  <= regWdata[PRE_LO +: PRE_W];
      clkDiv     <= regWdata[DIV_W-1:0];
      if (regWdata[BIT_DONE])  done  <= 1'b0;
      if (regWdata[BIT_TOUT])  toErr <= 1'b0;
      if (regWdata[BIT_RXERR]) rxErr <= 1'b0;
    end else if (busy && linkAck) begin
      busy <= 1'b0;
      done <= 1'b1;
      if (linkRxErr) rxErr <= 1'b1;
      if (linkTimeout) begin
        toErr <= 1'b1;
      end else begin
        msgSize <= linkRxLen;
        if (badLen) rxErr <= 1'b1;
      end
    end
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[BIT_BUSY]               = busy;
    ctrlWord[BIT_DONE]               = done;
    ctrlWord[BIT_IEN]                = irqEn;
    ctrlWord[BIT_TOUT]               = toErr;
    ctrlWord[TSEL_LO +: TSEL_W]      = timeoutSel;
    ctrlWord[BIT_RXERR]              = rxErr;
    ctrlWord[LEN_LO +: LEN_W]        = msgSize;
    ctrlWord[PRE_LO +: PRE_W]        = precharge;
    ctrlWord[DIV_W-1:0]              = clkDiv;
  end

  assign irq = done && irqEn;

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    busy && !linkAck |=> busy); // R3
  AST_ACK_FINISHES: assert property (@(posedge clk) disable iff (!rstN)
    busy && linkAck |=> !busy && done); // R4
  AST_BAD_LEN: assert property (@(posedge clk) disable iff (!rstN)
    busy && linkAck && !linkTimeout && badLen |=> rxErr); // R5
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    busy && !linkAck |=> $stable(msgSize) && $stable(clkDiv) && $stable(irqEn)); // R7
endmodule

// File: rtl/aux_regs_data.sv
module aux_regs_data
  import aux_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [31:0]       regWdata,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [LEN_W-1:0]  linkRxIdx,
  input  logic [7:0]        linkRxByte,
  input  logic [LEN_W-1:0]  linkTxIdx,
  output logic [31:0]       rdWord,
  output logic [7:0]        txByte
);
  logic [WORDS-1:0][31:0] words;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = 0; b < 4; b++) begin : g_lane
      always_ff @(posedge clk) begin
        if (!rstN) begin
          words[w][31-8*b -: 8] <= '0;
        end else if (strb.swWe && strb.swWord == ADDR_W'(w)) begin
          words[w][31-8*b -: 8] <= regWdata[31-8*b -: 8];
        end else if (strb.rxWe && linkRxIdx == LEN_W'(4*w+b)) begin
          words[w][31-8*b -: 8] <= linkRxByte;
        end
      end
    end
  end

  always_comb begin
    rdWord = '0;
    for (int w = 0; w < WORDS; w++)
      if (regAddr == ADDR_W'(w + 1)) rdWord = words[w];
    txByte = '0;
    for (int k = 0; k < BYTES; k++)
      if (linkTxIdx == LEN_W'(k)) txByte = words[k/4][31-8*(k%4) -: 8];
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.swWe && !strb.rxWe |=> $stable(words)); // R7
endmodule

// File: rtl/aux_regs.sv
module aux_regs
  import aux_regs_pkg::*;
#(
  parameter int CLK_KHZ = 100000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              linkReq,
  output logic [4:0]        linkTxLen,
  input  logic [4:0]        linkTxIdx,
  output logic [7:0]        linkTxByte,
  input  logic              linkRxWe,
  input  logic [4:0]        linkRxIdx,
  input  logic [7:0]        linkRxByte,
  input  logic              linkAck,
  input  logic              linkTimeout,
  input  logic              linkRxErr,
  input  logic [4:0]        linkRxLen,
  output logic [10:0]       cfgClkDiv,
  output logic [3:0]        cfgPrecharge,
  output logic [1:0]        cfgTimeoutSel,
  output logic              irq
);
  dpStrobe_t   strb;
  logic        busy;
  logic [31:0] ctrlWord, dataWord;

  aux_regs_ctrl #(.CLK_KHZ(CLK_KHZ)) u_ctrl (
    .clk, .rstN, .regWe, .regAddr, .regWdata,
    .linkAck, .linkTimeout, .linkRxErr, .linkRxLen, .linkRxWe, .linkRxIdx,
    .strb, .busy, .ctrlWord,
    .clkDiv(cfgClkDiv), .precharge(cfgPrecharge), .timeoutSel(cfgTimeoutSel), .irq
  );

  aux_regs_data u_data (
    .clk, .rstN, .strb, .regWdata, .regAddr, .linkRxIdx, .linkRxByte, .linkTxIdx,
    .rdWord(dataWord), .txByte(linkTxByte)
  );

  assign regRdata  = (regAddr == '0) ? ctrlWord : dataWord;
  assign linkReq   = busy;
  assign linkTxLen = ctrlWord[LEN_LO +: LEN_W];

  AST_W1C_DONE: assert property (@(posedge clk) disable iff (!rstN)
    regWe && regAddr == '0 && !busy && regWdata[BIT_DONE] |=> !ctrlWord[BIT_DONE] && !irq); // R6
endmodule

// File: tb/sim_aux_regs.sv
`timescale 1ns/1ps
module sim_aux_regs;
  logic clk = 0, rstN = 0;
  logic regWe = 0; logic [2:0] regAddr = 0; logic [31:0] regWdata = 0; logic [31:0] regRdata;
  logic linkReq; logic [4:0] linkTxLen; logic [4:0] linkTxIdx = 0; logic [7:0] linkTxByte;
  logic linkRxWe = 0; logic [4:0] linkRxIdx = 0; logic [7:0] linkRxByte = 0;
  logic linkAck = 0, linkTimeout = 0, linkRxErr = 0; logic [4:0] linkRxLen = 0;
  logic [10:0] cfgClkDiv; logic [3:0] cfgPrecharge; logic [1:0] cfgTimeoutSel; logic irq;

  int checks = 0, errors = 0; bit finished = 0;
  logic [7:0] expBytes [20];

  always #2.5 clk = ~clk;

  aux_regs u0 (.*);

  function automatic logic [31:0] packWord(int w);
    return {expBytes[4*w], expBytes[4*w+1], expBytes[4*w+2], expBytes[4*w+3]};
  endfunction

  function automatic logic [31:0] ctrlVal(bit b, bit d, bit ie, bit to, logic [1:0] ts,
                                          bit re, logic [4:0] sz, logic [3:0] pr, logic [10:0] dv);
    return {b, d, ie, to, ts, re, sz, pr, 5'b0, dv};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk); regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 0;
  endtask

  task automatic regRead(logic [2:0] a, output logic [31:0] d);
    regAddr = a; #0.5; d = regRdata;
  endtask

  task automatic rxWrite(int idx, logic [7:0] v);
    @(negedge clk); linkRxWe = 1; linkRxIdx = 5'(idx); linkRxByte = v;
    @(negedge clk); linkRxWe = 0;
  endtask

  task automatic doXfer(int len, int rxLen, bit tout, bit rerr);
    logic [31:0] r;
    int n;
    bit bad;
    for (int k = 0; k < 20; k++) expBytes[k] = 8'($urandom);
    for (int w = 0; w < 5; w++) regWrite(3'(w + 1), packWord(w));
    regWrite(0, ctrlVal(1, 0, 1, 0, 0, 0, 5'(len), 3, 50));
    chk("R3 linkReq", {31'b0, linkReq}, 1);
    chk("R3 txLen", {27'b0, linkTxLen}, len);
    for (int k = 0; k < len; k++) begin
      linkTxIdx = 5'(k); #0.5;
      chk("R2 tx byte", {24'b0, linkTxByte}, {24'b0, expBytes[k]});
    end
    regWrite(0, ctrlVal(1, 1, 0, 1, 2, 1, 7, 9, 77));
    regWrite(1, 32'hDEAD_BEEF);
    regRead(0, r);
    chk("R7 ctrl while busy", r, ctrlVal(1, 0, 1, 0, 0, 0, 5'(len), 3, 50));
    regRead(1, r);
    chk("R7 data while busy", r, packWord(0));
    chk("R3 busy held", {31'b0, linkReq}, 1);
    n = 0;
    if (!tout) n = (rxLen > 20) ? 20 : rxLen;
    for (int k = 0; k < n; k++) begin
      expBytes[k] = 8'($urandom);
      rxWrite(k, expBytes[k]);
    end
    @(negedge clk); linkAck = 1; linkTimeout = tout; linkRxErr = rerr; linkRxLen = 5'(rxLen);
    @(negedge clk); linkAck = 0; linkTimeout = 0; linkRxErr = 0;
    bad = !tout && (rxLen == 0 || rxLen > 20);
    regRead(0, r);
    chk("R4 R5 completion", r, ctrlVal(0, 1, 1, tout, 0, rerr | bad, tout ? 5'(len) : 5'(rxLen), 3, 50));
    chk("R9 irq on done", {31'b0, irq}, 1);
    for (int w = 0; w < 5; w++) begin
      regRead(3'(w + 1), r);
      chk("R8 rx packing", r, packWord(w));
    end
    regWrite(0, ctrlVal(0, 0, 1, 1, 0, 1, 4, 3, 50));
    regRead(0, r);
    chk("R6 partial clear", r, ctrlVal(0, 1, 1, 0, 0, 0, 4, 3, 50));
    chk("R9 irq held", {31'b0, irq}, 1);
    regWrite(0, ctrlVal(0, 1, 1, 0, 0, 0, 4, 3, 50));
    regRead(0, r);
    chk("R6 done clear", r, ctrlVal(0, 0, 1, 0, 0, 0, 4, 3, 50));
    chk("R9 irq cleared", {31'b0, irq}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int rl;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    regRead(0, r);
    chk("R1 reset ctrl", r, ctrlVal(0, 0, 0, 0, 0, 0, 0, 3, 11'((100000 + 1000) / 2000)));
    regRead(3, r);
    chk("R1 reset data", r, 0);
    chk("R1 reset irq", {31'b0, irq}, 0);

    regWrite(0, ctrlVal(0, 0, 0, 0, 1, 0, 0, 5, 123));
    chk("R10 clkdiv", {21'b0, cfgClkDiv}, 123);
    chk("R10 precharge", {28'b0, cfgPrecharge}, 5);
    chk("R10 timeout code", {30'b0, cfgTimeoutSel}, 1);
    chk("R3 no start without busy bit", {31'b0, linkReq}, 0);

    @(negedge clk); linkAck = 1; linkRxLen = 5;
    @(negedge clk); linkAck = 0;
    regRead(0, r);
    chk("R4 idle ack ignored", r, ctrlVal(0, 0, 0, 0, 1, 0, 0, 5, 123));

    regWrite(2, 32'h1122_3344);
    rxWrite(5, 8'hAA);
    regRead(2, r);
    chk("R8 idle rx ignored", r, 32'h1122_3344);

    doXfer(20, 20, 0, 0);
    doXfer(1, 0, 0, 0);
    doXfer(3, 25, 0, 0);
    doXfer(8, 4, 1, 0);
    for (int t = 0; t < 30; t++) begin
      case ($urandom % 8)
        0: rl = 0;
        1: rl = 21 + int'($urandom % 11);
        default: rl = 1 + int'($urandom % 20);
      endcase
      doXfer(1 + int'($urandom % 20), rl, ($urandom % 6) == 0, ($urandom % 6) == 0);
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule